// File: doc/BRIEF.md
# Power-Good Supervisor with Qualification Timeout and Margin Hold

This block decides when a set of switched supply rails may be declared good. Each channel supplies a flag, already synchronized, that says whether its switched output sits above the good fraction of its own input. The analog side sets that fraction to 92.5 % of the input, with 0.5 % of hysteresis on the rising edge. The block also receives one undervoltage-ok flag per channel and a single enable-ok level. A channel can be left out of the decision through an active mask.

Power-good rises only after every active output, every undervoltage flag and the enable level have all stayed good for one unbroken qualification window. If any of them drops, power-good falls on the next clock and the window starts again from zero. The window length is a run-time count, and a parameter sets a floor under it. Left at zero, the count gives the floor, which stands for the 200 µs minimum at the chosen clock.

An active-low margin input passes through a synchronizer and a deglitch filter. While it is held low, power-good, the registered fault output and the qualification counter all keep their values, so rails can be moved during test without disturbing the system. An open-drain style pull-down output is the inverse of power-good.

Top module: `power_good_supervisor`

## Requirements
- R1: After reset, pg is 0, pg_pull_dn is 1 and fault_n is 1.
- R2: With margin released, pg goes to 1 on the L-th consecutive rising edge at which the qualifying condition is true. The condition is true when every active channel's out_good bit is 1, every uv_ok bit is 1 and en_ok is 1. L = max(tmo_count, MIN_TIMEOUT).
- R3: A tmo_count smaller than MIN_TIMEOUT, including 0, gives a window of MIN_TIMEOUT edges.
- R4: With margin released, an edge at which the condition is false makes pg 0 after that edge and restarts the count from zero.
- R5: A channel whose chan_active bit is 0 has no effect through its out_good bit.
- R6: While the filtered margin is active (margin_n held low), pg and fault_n keep their values whatever the other inputs do, and counting pauses.
- R7: A low pulse on margin_n shorter than GLITCH_CYC clocks does not activate margin.
- R8: With margin released, fault_n after an edge equals the inverse of fault_req at that edge.
- R9: pg_pull_dn is always the inverse of pg: it pulls low while power is not good and releases otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_good | input | N_CH | Per-channel flag: output above the good fraction of its input |
| chan_active | input | N_CH | Per-channel mask: 1 means the channel takes part |
| uv_ok | input | N_CH | Per-channel undervoltage-ok flag |
| en_ok | input | 1 | Enable level is above its rising threshold |
| fault_req | input | 1 | Fault request from the tracking logic |
| margin_n | input | 1 | Active-low margin request, asynchronous |
| tmo_count | input | TMO_W | Qualification window in clocks |
| pg | output | 1 | Power-good level |
| pg_pull_dn | output | 1 | Open-drain drive: 1 pulls the power-good line low |
| fault_n | output | 1 | Registered active-low fault |

## Verification
The margin hold and the drop of the qualifying condition can land on the same edge. If the drop wins, power-good falls even though margin is held. The bench provokes this by letting the filtered margin take effect first, then dropping en_ok and raising fault_req while margin is held, and it expects pg and fault_n to keep their values. A second case pairs a sub-threshold margin glitch with an enable drop straight after it, and there the drop must win on the very next edge.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   // Width needed to hold the value v (at least 1 bit).
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((v >> w) != 0) w++;
      return w;
   endfunction

   // Wider of two widths.
   function automatic int unsigned wider(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgs_deglitch.sv
// Two-flop synchronizer followed by a stability filter: the filtered level
// follows the synchronized level only after it has differed for HOLD_CYC clocks.
module pgs_deglitch #(
   parameter int unsigned HOLD_CYC = 20,
   parameter bit          RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o
);
   import pgs_pkg::*;

   localparam int unsigned CW = bits_for(HOLD_CYC);

   logic sync_a, sync_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_a <= RST_VAL;
         sync_b <= RST_VAL;
      end else begin
         sync_a <= raw_i;
         sync_b <= sync_a;
      end
   end

   generate
      if (HOLD_CYC == 0) begin : g_bypass
         assign level_o = sync_b;
      end else begin : g_filter
         logic [CW-1:0] run_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= RST_VAL;
            end else if (sync_b == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(HOLD_CYC - 1)) begin
               run_q <= '0;
               lvl_q <= sync_b;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign level_o = lvl_q;
      end
   endgenerate

endmodule

// File: rtl/pgs_qualify.sv
// Combines the per-channel flags into a single qualifying condition.
module pgs_qualify #(
   parameter int unsigned N_CH = 3
) (
   input  logic [N_CH-1:0] out_good,
   input  logic [N_CH-1:0] chan_active,
   input  logic [N_CH-1:0] uv_ok,
   input  logic            en_ok,
   output logic            all_ok
);
   logic [N_CH-1:0] chan_ok;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign chan_ok[c] = uv_ok[c] & (out_good[c] | ~chan_active[c]);
      end
   endgenerate

   assign all_ok = en_ok & (&chan_ok);

endmodule

// File: rtl/pgs_timer.sv
// Qualification window counter. Restarts on any loss of the condition;
// everything is held while hold_i is set.
module pgs_timer #(
   parameter int unsigned TMO_W       = 20,
   parameter int unsigned MIN_TIMEOUT = 40000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             ok_i,
   input  logic [TMO_W-1:0] tmo_count,
   output logic             good_o
);
   import pgs_pkg::*;

   localparam int unsigned CW = wider(TMO_W, bits_for(MIN_TIMEOUT));

   logic [CW-1:0] limit;
   logic [CW-1:0] cnt_q;
   logic          good_q;

   always_comb begin
      if (CW'(tmo_count) > CW'(MIN_TIMEOUT)) limit = CW'(tmo_count);
      else                                   limit = CW'(MIN_TIMEOUT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         good_q <= 1'b0;
      end else if (!hold_i) begin
         if (!ok_i) begin
            cnt_q  <= '0;
            good_q <= 1'b0;
         end else if (!good_q) begin
            if (cnt_q == limit - 1'b1) good_q <= 1'b1;
            else                       cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign good_o = good_q;

endmodule

// File: rtl/power_good_supervisor.sv
module power_good_supervisor #(
   parameter int unsigned N_CH        = 3,
   parameter int unsigned TMO_W       = 20,
   parameter int unsigned MIN_TIMEOUT = 40000,
   parameter int unsigned GLITCH_CYC  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  out_good,
   input  logic [N_CH-1:0]  chan_active,
   input  logic [N_CH-1:0]  uv_ok,
   input  logic             en_ok,
   input  logic             fault_req,
   input  logic             margin_n,
   input  logic [TMO_W-1:0] tmo_count,
   output logic             pg,
   output logic             pg_pull_dn,
   output logic             fault_n
);

   generate
      if (N_CH < 1 || N_CH > 32) begin : g_bad_nch
         $error("N_CH out of range");
      end
      if (TMO_W < 1) begin : g_bad_tw
         $error("TMO_W must be at least 1");
      end
      if (MIN_TIMEOUT < 1) begin : g_bad_min
         $error("MIN_TIMEOUT must be at least 1");
      end
   endgenerate

   logic margin_lvl;
   logic margin_hold;
   logic all_ok;
   logic good;
   logic fault_n_q;

   pgs_deglitch #(.HOLD_CYC(GLITCH_CYC), .RST_VAL(1'b1)) u_margin (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (margin_n),
      .level_o (margin_lvl)
   );

   assign margin_hold = ~margin_lvl;

   pgs_qualify #(.N_CH(N_CH)) u_qual (
      .out_good    (out_good),
      .chan_active (chan_active),
      .uv_ok       (uv_ok),
      .en_ok       (en_ok),
      .all_ok      (all_ok)
   );

   pgs_timer #(.TMO_W(TMO_W), .MIN_TIMEOUT(MIN_TIMEOUT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (margin_hold),
      .ok_i      (all_ok),
      .tmo_count (tmo_count),
      .good_o    (good)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            fault_n_q <= 1'b1;
      else if (!margin_hold) fault_n_q <= ~fault_req;
   end

   assign pg         = good;
   assign pg_pull_dn = ~good;
   assign fault_n    = fault_n_q;

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
   parameter int unsigned MIN_TIMEOUT = 40000
) (
   input logic clk,
   input logic rst_n,
   input logic all_ok,
   input logic margin_hold,
   input logic fault_req,
   input logic pg,
   input logic pg_pull_dn,
   input logic fault_n
);
   logic [31:0] streak;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                streak <= '0;
      else if (!margin_hold) begin
         if (!all_ok)            streak <= '0;
         else if (streak != '1)  streak <= streak + 1'b1;
      end
   end

   // R4: a lost condition clears power-good on the next edge
   a_r4_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!margin_hold && !all_ok) |=> !pg);

   // R2 / R3: power-good never rises before a full minimum window
   a_r3_min_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg) |-> (streak >= MIN_TIMEOUT));

   // R6: margin hold freezes both outputs
   a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      margin_hold |=> ($stable(pg) && $stable(fault_n)));

   // R8: fault output follows the request when not held
   a_r8_fault_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !margin_hold |=> (fault_n == !$past(fault_req)));

   // R9: pull-down is the inverse of power-good
   a_r9_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      pg_pull_dn != pg);

endmodule

bind power_good_supervisor pgs_checker #(.MIN_TIMEOUT(MIN_TIMEOUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .all_ok      (all_ok),
   .margin_hold (margin_hold),
   .fault_req   (fault_req),
   .pg          (pg),
   .pg_pull_dn  (pg_pull_dn),
   .fault_n     (fault_n)
);

// File: tb/tb_power_good_supervisor.sv
`timescale 1ns/1ps
module tb_power_good_supervisor;
   localparam int N   = 3;
   localparam int TW  = 8;
   localparam int MIN = 12;
   localparam int GL  = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic [N-1:0]  out_good = '0, chan_active = '1, uv_ok = '0;
   logic          en_ok = 0, fault_req = 0, margin_n = 1;
   logic [TW-1:0] tmo_count = '0;
   logic pg, pg_pull_dn, fault_n;

   int checks = 0, errors = 0;
   int ecnt = 0;
   bit epg = 0, efault_n = 1, frozen = 0;

   always #2.5 clk = ~clk;

   power_good_supervisor #(.N_CH(N), .TMO_W(TW), .MIN_TIMEOUT(MIN), .GLITCH_CYC(GL)) dut (
      .clk(clk), .rst_n(rst_n), .out_good(out_good), .chan_active(chan_active),
      .uv_ok(uv_ok), .en_ok(en_ok), .fault_req(fault_req), .margin_n(margin_n),
      .tmo_count(tmo_count), .pg(pg), .pg_pull_dn(pg_pull_dn), .fault_n(fault_n));

   function automatic bit cond_ok();
      return en_ok && (&uv_ok) && (&(out_good | ~chan_active));
   endfunction

   function automatic int win_len();
      return (int'(tmo_count) > MIN) ? int'(tmo_count) : MIN;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: inputs already set at negedge; update model at the edge
   task automatic step(input string req);
      bit q;
      q = cond_ok();
      @(posedge clk);
      if (!frozen) begin
         efault_n = !fault_req;
         if (!q) begin epg = 0; ecnt = 0; end
         else if (!epg) begin
            if (ecnt == win_len() - 1) epg = 1; else ecnt++;
         end
      end
      @(negedge clk);
      chk(req, pg, epg);
      chk("R9", pg_pull_dn, !epg);
      chk("R8", fault_n, efault_n);
   endtask

   task automatic all_good();
      out_good = '1; uv_ok = '1; en_ok = 1; chan_active = '1;
   endtask

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", pg, 0); chk("R1", pg_pull_dn, 1); chk("R1", fault_n, 1);
      rst_n = 1;
      @(negedge clk);

      // R2: exact window of 20 edges
      tmo_count = 20; all_good();
      for (int i = 0; i < 19; i++) step("R2");
      chk("R2", pg, 0);
      step("R2");
      chk("R2", pg, 1);

      // R4: drop of one channel clears and restarts
      out_good[1] = 0; step("R4"); chk("R4", pg, 0);
      out_good[1] = 1;
      for (int i = 0; i < 10; i++) step("R4");
      uv_ok[2] = 0; step("R4"); uv_ok[2] = 1;
      for (int i = 0; i < 19; i++) step("R4");
      chk("R4", pg, 0);
      step("R4"); chk("R4", pg, 1);

      // R3: small and zero counts use the minimum window
      tmo_count = 3; en_ok = 0; step("R3"); en_ok = 1;
      for (int i = 0; i < MIN - 1; i++) step("R3");
      chk("R3", pg, 0);
      step("R3"); chk("R3", pg, 1);
      tmo_count = 0; en_ok = 0; step("R3"); en_ok = 1;
      for (int i = 0; i < MIN; i++) step("R3");
      chk("R3", pg, 1);

      // R5: inactive channel with a bad output flag is ignored
      chan_active = 3'b101; out_good[1] = 0;
      for (int i = 0; i < 5; i++) step("R5");
      chk("R5", pg, 1);
      chan_active = '1; step("R5"); chk("R5", pg, 0);
      out_good[1] = 1;
      for (int i = 0; i < MIN; i++) step("R5");

      // R7: short margin glitch then enable drop: must fall at once
      margin_n = 0;
      repeat (GL - 1) step("R7");
      margin_n = 1;
      en_ok = 0;
      for (int i = 0; i < 2 * GL + 4; i++) step("R7");
      chk("R7", pg, 0);
      en_ok = 1;
      for (int i = 0; i < MIN; i++) step("R7");
      chk("R7", pg, 1);

      // R6: margin held, then drop condition and raise fault: nothing moves
      margin_n = 0;
      for (int i = 0; i < GL + 4; i++) step("R6");
      frozen = 1;
      en_ok = 0; fault_req = 1;
      for (int i = 0; i < 2 * MIN; i++) step("R6");
      chk("R6", pg, 1); chk("R6", fault_n, 1);
      margin_n = 1;
      for (int i = 0; i < 2; i++) @(negedge clk);
      // release latency: wait, then resume model from known state
      repeat (GL + 4) @(negedge clk);
      frozen = 0; epg = 0; ecnt = 0; efault_n = 0;
      step("R6"); chk("R6", pg, 0); chk("R6", fault_n, 0);
      fault_req = 0; en_ok = 1;

      // random phase: R2 R4 R5 R8
      for (int seg = 0; seg < 60; seg++) begin
         en_ok = 0; tmo_count = TW'($urandom_range(0, 30)); step("R4");
         chan_active = N'($urandom_range(1, 7));
         all_good();
         chan_active = N'($urandom_range(1, 7));
         for (int i = 0; i < 50; i++) begin
            out_good = '1; uv_ok = '1; en_ok = 1;
            if ($urandom_range(0, 40) == 0) out_good = N'($urandom);
            if ($urandom_range(0, 80) == 0) uv_ok = N'($urandom);
            if ($urandom_range(0, 80) == 0) en_ok = 0;
            fault_req = ($urandom_range(0, 7) == 0);
            step("R2");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule